// File: doc/BRIEF.md
# Instruction Abort Capture Sequencer

This block handles instruction aborts inside a small processor core with 8-bit and 16-bit modes. An active-low abort input is sampled on every rising clock edge. A low sample marks an abort as pending and records the location of the opcode in progress. From the next cycle on, the block forces every register write enable coming from the datapath to zero. The aborted instruction still completes its bus cycles, but it changes no register.

When the datapath signals the last cycle of the instruction, the block runs an interrupt entry sequence. It first emits stack push requests, one byte per cycle: the return address, which is the aborted opcode's own location, followed by the processor status. It then fetches the abort vector from a two-byte location whose address depends on the operating mode. The pending flag is cleared at the cycle the vector fetch begins. Because of this, any number of abort pulses inside one instruction produce only one entry sequence.

Top module: `abt_seq_top`

## Requirements
- R1: After reset no abort is pending, `push_valid` and `vec_valid` are 0, and `reg_we_out` equals `reg_we_in`.
- R2: `abort_n` low at a rising clock edge registers an abort, whether it is a one-cycle pulse or a level held over several cycles. From the next cycle on, `reg_we_out` is all zeros.
- R3: While no abort is pending, `reg_we_out` follows `reg_we_in` bit for bit. While an abort is pending, including the instruction's final cycle and every push cycle, `reg_we_out` is all zeros.
- R4: The entry sequence starts only at the rising edge where `insn_end` is 1 and an abort is pending or is being sampled. The first push appears in the cycle after that edge.
- R5: The pushed return address is the `op_addr` value present in the cycle where the abort was first sampled. `op_addr[23:16]` is the bank and `op_addr[15:0]` is the in-bank address.
- R6: When `emu_mode` is 0 at the start edge, the block pushes four bytes on consecutive cycles, each with `push_valid`=1, in this order: bank, address bits 15:8, address bits 7:0, `status_in`.
- R7: When `emu_mode` is 1 at the start edge, the block pushes three bytes in this order: address bits 15:8, address bits 7:0, `status_in`. No bank byte is pushed.
- R8: In the two cycles right after the last push, `vec_valid` is 1 and `vec_addr` is first the low-byte address and then the high-byte address. The addresses are 0x00FFE8 and 0x00FFE9 in native mode, and 0x00FFF8 and 0x00FFF9 in emulation mode. The write gating is released from the first vector cycle on.
- R9: Several abort pulses inside one instruction produce exactly one entry sequence, and it carries the address from the first pulse.
- R10: An abort first sampled in the instruction's final cycle does not gate that cycle's writes, but it still starts the entry sequence at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort_n | input | 1 | Abort request, active low |
| emu_mode | input | 1 | 1 = emulation mode, 0 = native mode |
| insn_end | input | 1 | High in the last cycle of each instruction |
| op_addr | input | 24 | Location of the current instruction's opcode (bank and address) |
| status_in | input | 8 | Processor status byte to push |
| reg_we_in | input | NWE | Register write requests from the datapath |
| reg_we_out | output | NWE | Gated register write enables |
| push_valid | output | 1 | Stack push request |
| push_data | output | 8 | Byte to push |
| vec_valid | output | 1 | Vector fetch request |
| vec_addr | output | 24 | Vector fetch byte address |

## Verification
The assertions check these relations on every cycle:
- the pending flag sets after any low sample;
- the saved address stays stable while an abort is pending;
- no write escapes during a push;
- the sequence opens with a push;
- the vector cycles come as an aligned pair inside the two legal vector ranges.

Only the bench scenarios can show the exact byte order and values for each mode, the cycle where gating starts, and the merging of repeated pulses into one sequence. The same holds for the final-cycle abort, which starts the sequence without blocking that cycle's writes.

// File: rtl/abt_pkg.sv
package abt_pkg;

  localparam int ADDR_W = 24;

  localparam logic [ADDR_W-1:0] VEC_NATIVE = 24'h00FFE8;
  localparam logic [ADDR_W-1:0] VEC_EMUL   = 24'h00FFF8;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PUSH = 2'd1,
    SQ_VLO  = 2'd2,
    SQ_VHI  = 2'd3
  } seq_state_t;

  // number of stack bytes in the entry frame
  function automatic logic [2:0] frame_len(input logic emu);
    return emu ? 3'd3 : 3'd4;
  endfunction

  // byte pushed at position idx of the frame
  function automatic logic [7:0] frame_byte(input logic emu,
                                            input logic [1:0] idx,
                                            input logic [ADDR_W-1:0] ra,
                                            input logic [7:0] st);
    logic [1:0] slot;
    slot = emu ? 2'(idx + 2'd1) : idx;
    case (slot)
      2'd0:    return ra[23:16];
      2'd1:    return ra[15:8];
      2'd2:    return ra[7:0];
      default: return st;
    endcase
  endfunction

  // vector byte address: base for the mode plus the byte select
  function automatic logic [ADDR_W-1:0] vector_at(input logic emu, input logic hi);
    return (emu ? VEC_EMUL : VEC_NATIVE) + {{(ADDR_W-1){1'b0}}, hi};
  endfunction

endpackage

// File: rtl/abt_capture.sv
module abt_capture
  import abt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_n,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              clr,
  output logic              abort_hit,
  output logic              pend,
  output logic [ADDR_W-1:0] ret_addr
);

  assign abort_hit = ~abort_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      ret_addr <= '0;
    end else begin
      if (clr) begin
        pend <= 1'b0;
      end else if (abort_hit) begin
        pend <= 1'b1;
      end
      if (abort_hit && !pend && !clr) begin
        ret_addr <= op_addr;
      end
    end
  end

  // R2
  set_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_hit && !clr) |=> pend);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> $stable(ret_addr));

endmodule

// File: rtl/abt_we_gate.sv
module abt_we_gate #(
  parameter int NWE = 8
) (
  input  logic [NWE-1:0] we_in,
  input  logic           block,
  output logic [NWE-1:0] we_out
);

  for (genvar i = 0; i < NWE; i++) begin : g_bit
    assign we_out[i] = we_in[i] & ~block;
  end

endmodule

// File: rtl/abt_entry_fsm.sv
module abt_entry_fsm
  import abt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  logic              pend,
  input  logic              abort_hit,
  input  logic              emu_mode,
  input  logic [7:0]        status_in,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic              start,
  output logic              vec_begin,
  output logic              push_valid,
  output logic [7:0]        push_data,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);

  seq_state_t state;
  logic [1:0] idx;
  logic       emu_l;
  logic [7:0] st_l;
  logic       last_push;

  assign start     = (state == SQ_IDLE) && insn_end && (pend || abort_hit);
  assign last_push = ({1'b0, idx} == 3'(frame_len(emu_l) - 3'd1));
  assign vec_begin = (state == SQ_PUSH) && last_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      idx   <= '0;
      emu_l <= 1'b0;
      st_l  <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state <= SQ_PUSH;
          idx   <= '0;
          emu_l <= emu_mode;
          st_l  <= status_in;
        end
        SQ_PUSH: begin
          if (last_push) state <= SQ_VLO;
          else           idx   <= 2'(idx + 2'd1);
        end
        SQ_VLO:  state <= SQ_VHI;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign push_valid = (state == SQ_PUSH);
  assign push_data  = push_valid ? frame_byte(emu_l, idx, ret_addr, st_l) : 8'h00;
  assign vec_valid  = (state == SQ_VLO) || (state == SQ_VHI);
  assign vec_addr   = vec_valid ? vector_at(emu_l, state == SQ_VHI) : '0;

  // R4
  start_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> push_valid);

  // R8
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_addr[0]) |=> (vec_valid && vec_addr == $past(vec_addr) + 24'd1));

  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[23:4] == 20'h00FFE || vec_addr[23:4] == 20'h00FFF));

  // R6
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && vec_valid));

endmodule

// File: rtl/abt_seq_top.sv
module abt_seq_top
  import abt_pkg::*;
#(
  parameter int NWE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_n,
  input  logic              emu_mode,
  input  logic              insn_end,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        status_in,
  input  logic [NWE-1:0]    reg_we_in,
  output logic [NWE-1:0]    reg_we_out,
  output logic              push_valid,
  output logic [7:0]        push_data,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);

  logic              abort_hit;
  logic              pend;
  logic [ADDR_W-1:0] ret_addr;
  logic              seq_start;
  logic              vec_begin;

  abt_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_n   (abort_n),
    .op_addr   (op_addr),
    .clr       (vec_begin),
    .abort_hit (abort_hit),
    .pend      (pend),
    .ret_addr  (ret_addr)
  );

  abt_we_gate #(.NWE(NWE)) u_gate (
    .we_in  (reg_we_in),
    .block  (pend),
    .we_out (reg_we_out)
  );

  abt_entry_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_end   (insn_end),
    .pend       (pend),
    .abort_hit  (abort_hit),
    .emu_mode   (emu_mode),
    .status_in  (status_in),
    .ret_addr   (ret_addr),
    .start      (seq_start),
    .vec_begin  (vec_begin),
    .push_valid (push_valid),
    .push_data  (push_data),
    .vec_valid  (vec_valid),
    .vec_addr   (vec_addr)
  );

  // R3
  push_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (reg_we_out == '0));

  // R8
  vec_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (reg_we_out == reg_we_in));

  // R9
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_begin |-> pend);

  // R4
  start_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> insn_end);

endmodule

// File: tb/test_abt_seq_top.sv
module test_abt_seq_top;
  import abt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NWE = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              abort_n = 1'b1;
  logic              emu_mode = 1'b0;
  logic              insn_end = 1'b0;
  logic [23:0]       op_addr = '0;
  logic [7:0]        status_in = '0;
  logic [NWE-1:0]    reg_we_in = '0;
  logic [NWE-1:0]    reg_we_out;
  logic              push_valid;
  logic [7:0]        push_data;
  logic              vec_valid;
  logic [23:0]       vec_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string cur_tag = "R1";
  logic [31:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  abt_seq_top #(.NWE(NWE)) i_abt_seq_top (
    .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .emu_mode(emu_mode),
    .insn_end(insn_end), .op_addr(op_addr), .status_in(status_in),
    .reg_we_in(reg_we_in), .reg_we_out(reg_we_out), .push_valid(push_valid),
    .push_data(push_data), .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop the expected item for every push or vector cycle
  always @(negedge clk) begin
    if (rst_n && (push_valid || vec_valid)) begin
      logic [31:0] got;
      got = push_valid ? {8'h01, 16'h0, push_data} : {8'h02, vec_addr};
      if (expq.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected output"}, got, 32'h0);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(got == e, cur_tag, got, e);
      end
    end
  end

  // one instruction of len cycles; ab1/ab2 are cycles with abort low (-1 none)
  task automatic run_insn(input string tag, input bit emu, input logic [23:0] ad,
                          input logic [7:0] st, input int len, input int ab1,
                          input int ab2, input int ab3);
    int first_ab;
    bit any_ab;
    first_ab = -1;
    cur_tag = tag;
    emu_mode = emu;
    status_in = st;
    op_addr = ad;
    for (int c = 0; c < len; c++) begin
      insn_end = (c == len - 1);
      abort_n = !(c == ab1 || c == ab2 || c == ab3);
      reg_we_in = 8'(8'h5A ^ c);
      @(negedge clk);
      if (first_ab >= 0 && c > first_ab)
        check(reg_we_out == '0, {tag, " R3 gated"}, 32'(reg_we_out), 32'h0);
      else
        check(reg_we_out == reg_we_in, {tag, " R3 pass"}, 32'(reg_we_out), 32'(reg_we_in));
      if (!abort_n && first_ab < 0) first_ab = c;
      @(posedge clk); #1;
    end
    insn_end = 1'b0;
    abort_n = 1'b1;
    any_ab = (first_ab >= 0);
    if (any_ab) begin
      int np;
      if (!emu) expq.push_back({8'h01, 16'h0, ad[23:16]});
      expq.push_back({8'h01, 16'h0, ad[15:8]});
      expq.push_back({8'h01, 16'h0, ad[7:0]});
      expq.push_back({8'h01, 16'h0, st});
      expq.push_back({8'h02, emu ? 24'h00FFF8 : 24'h00FFE8});
      expq.push_back({8'h02, emu ? 24'h00FFF9 : 24'h00FFE9});
      np = emu ? 3 : 4;
      for (int k = 0; k < np + 2; k++) begin
        reg_we_in = 8'hA5;
        @(negedge clk);
        if (k < np)
          check(reg_we_out == '0, {tag, " R3 push gated"}, 32'(reg_we_out), 32'h0);
        else
          check(reg_we_out == 8'hA5, {tag, " R8 released"}, 32'(reg_we_out), 32'hA5);
        @(posedge clk); #1;
      end
    end
    // R4/R9: everything expected has come out and nothing more follows
    check(expq.size() == 0, {tag, " R9 queue drained"}, 32'(expq.size()), 32'h0);
    @(negedge clk);
    check(!push_valid && !vec_valid, {tag, " R9 idle after"}, {30'h0, push_valid, vec_valid}, 32'h0);
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    reg_we_in = 8'h3C;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(!push_valid && !vec_valid, "R1 outputs idle in reset", {30'h0, push_valid, vec_valid}, 32'h0);
    check(reg_we_out == 8'h3C, "R1 pass-through in reset", 32'(reg_we_out), 32'h3C);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_we_out == 8'h3C && !push_valid, "R1 after reset", 32'(reg_we_out), 32'h3C);
    @(posedge clk); #1;

    run_insn("R3 no abort", 1'b0, 24'h01_2000, 8'h11, 4, -1, -1, -1);
    run_insn("R6 native pulse R2 R5 R8", 1'b0, 24'h12_3456, 8'h5A, 5, 1, -1, -1);
    run_insn("R7 emulation pulse R8", 1'b1, 24'h00_ABCD, 8'h33, 4, 0, -1, -1);
    run_insn("R9 repeated pulses", 1'b0, 24'h7E_0102, 8'hC4, 6, 0, 2, 4);
    run_insn("R2 held level", 1'b1, 24'h00_F00D, 8'h81, 6, 1, 2, 3);
    run_insn("R10 final cycle abort", 1'b1, 24'h00_1234, 8'h24, 3, 2, -1, -1);
    run_insn("R10 final cycle native", 1'b0, 24'h3F_FFFE, 8'hFF, 1, 0, -1, -1);
    run_insn("R3 clean after", 1'b0, 24'h02_0000, 8'h00, 3, -1, -1, -1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule